// File: doc/BRIEF.md
# Virtual Segment Decoder With Privilege Check

This block sits at the front of address translation for a 64-bit virtual address. Each request gives it a virtual address, the privilege level of the current context and whether the access is a store. One clock later it answers with one of three results. The address may be unmapped, and then a direct physical address is produced. The address may be mapped, and then the request must go on to a translation lookaside buffer, which is not part of this block. Otherwise the block reports an address-error fault, with a load variant and a store variant.

The two top address bits select one of four regions. In the top region there is a 32-bit compatibility window, where address bits 61 to 31 are all ones. Inside that window, bits 30 and 29 pick a kernel mapped area, a supervisor mapped area, or one of two kernel unmapped areas. The requested privilege is checked first. After that, a mapped address outside the compatibility window is checked against a virtual limit, `MAX_VA`. An unmapped physical address is checked against a physical limit, `MAX_PA`.

Top module: `vseg_decoder`

## Requirements
- R1: A request presented with `req_valid` high produces its result one clock later with `rsp_valid` high. A cycle without a request gives `rsp_valid`, `rsp_mapped`, `rsp_fault` and `rsp_paddr` all zero on the next clock.
- R2: Region `vaddr[63:62]`=00 is mapped and needs user level. Region 01 is mapped and needs supervisor level.
- R3: Region 10 is unmapped and needs kernel level. Its physical address is `vaddr[58:0]` zero-extended. Bits 61 to 59 do not change the result.
- R4: The compatibility flag is set when `vaddr[61:31]` are all ones. In region 11 with the flag set, `vaddr[30:29]`=11 is mapped and needs kernel level, and 10 is mapped and needs supervisor level.
- R5: In region 11 with the compatibility flag set, `vaddr[30:29]`=01 or 00 is unmapped and needs kernel level. Its physical address is `vaddr[28:0]` zero-extended.
- R6: In region 11 without the compatibility flag, the address is mapped and needs kernel level.
- R7: `cur_level` is encoded as 0 = user, 1 = supervisor, 2 = kernel, and 3 ranks as kernel. The ranks are ordered user < supervisor < kernel. A level that ranks below the required level gives a fault.
- R8: `rsp_fault` is encoded as 0 = none, 1 = load address error, 2 = store address error. The store code is used exactly when `is_store` is 1.
- R9: A mapped address that has no privilege fault, has the compatibility flag clear, and has `vaddr[61:0]` > `MAX_VA` gives a fault. This holds in every region, because the flag is computed from bits 61 to 31 whatever the region. With the flag set, the check is skipped.
- R10: An unmapped address that has no privilege fault and whose physical address is > `MAX_PA` gives a fault.
- R11: A fault forces `rsp_mapped`=0 and `rsp_paddr`=0. A mapped result drives `rsp_paddr`=0.
- R12: While `rst` is high, every output is zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| vaddr | input | 64 | Virtual address |
| cur_level | input | 2 | Current privilege level (0 user, 1 supervisor, 2/3 kernel) |
| is_store | input | 1 | The access is a store |
| rsp_valid | output | 1 | Result valid, one clock after the request |
| rsp_mapped | output | 1 | Address must be translated by the lookaside buffer |
| rsp_paddr | output | 64 | Direct physical address for unmapped results, else zero |
| rsp_fault | output | 2 | Fault code (0 none, 1 load error, 2 store error) |

## Verification
Directed addresses cover every region and all four compatibility sub-windows. Each is tried at all four level codes, so the required level of each segment is separated from its neighbours. The ignored cache bits of region 10 are flipped, and addresses are placed at the limits and just over them. This separates the virtual check from the physical check and shows that the compatibility window skips the virtual limit. The compatibility pattern is also used in the low regions. The random phase biases the address toward each segment and mixes in idle cycles and both access types. This exposes a wrong fault variant, a wrong priority between checks, or stale output after an idle cycle.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int VA_W = 64;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_SUPER  = 2'd1,
    LVL_KERNEL = 2'd2
  } level_t;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LOAD  = 2'd1,
    FLT_STORE = 2'd2
  } fault_t;

  typedef struct packed {
    level_t            need;
    logic              mapped;
    logic              compat;
    logic [VA_W-1:0]   direct_pa;
  } seg_info_t;

  function automatic level_t rank_of(input logic [1:0] code);
    return (code == 2'd3) ? LVL_KERNEL : level_t'(code);
  endfunction
endpackage

// File: rtl/vseg_region_decode.sv
module vseg_region_decode
  import vseg_pkg::*;
#(
  parameter int XKPHYS_HI = 58,
  parameter int COMPAT_HI = 28
) (
  input  logic [VA_W-1:0] va,
  output seg_info_t       info
);
  localparam int WIN_LO  = COMPAT_HI + 3;
  localparam int WIN_W   = 62 - WIN_LO;

  logic [1:0] region;
  logic [1:0] sub;
  logic       compat;

  assign region = va[63:62];
  assign sub    = va[COMPAT_HI+2:COMPAT_HI+1];
  assign compat = (va[61:WIN_LO] == {WIN_W{1'b1}});

  always_comb begin
    info.need      = LVL_KERNEL;
    info.mapped    = 1'b1;
    info.compat    = compat;
    info.direct_pa = '0;
    unique case (region)
      2'b00: info.need = LVL_USER;
      2'b01: info.need = LVL_SUPER;
      2'b10: begin
        info.mapped    = 1'b0;
        info.direct_pa = {{(VA_W-XKPHYS_HI-1){1'b0}}, va[XKPHYS_HI:0]};
      end
      default: begin
        if (compat) begin
          unique case (sub)
            2'b11: info.need = LVL_KERNEL;
            2'b10: info.need = LVL_SUPER;
            default: begin
              info.mapped    = 1'b0;
              info.direct_pa = {{(VA_W-COMPAT_HI-1){1'b0}}, va[COMPAT_HI:0]};
            end
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/vseg_limit_check.sv
module vseg_limit_check
  import vseg_pkg::*;
#(
  parameter logic [63:0] MAX_VA = 64'h0000_00FF_FFFF_FFFF,
  parameter logic [63:0] MAX_PA = 64'h0000_000F_FFFF_FFFF
) (
  input  logic [VA_W-1:0] va,
  input  seg_info_t       info,
  input  logic [1:0]      cur_level,
  input  logic            is_store,
  output fault_t          fault,
  output logic            mapped,
  output logic [VA_W-1:0] pa
);
  localparam logic [63:0] VA_LIM = MAX_VA;
  localparam logic [63:0] PA_LIM = MAX_PA;

  logic   priv_bad;
  logic   va_bad;
  logic   pa_bad;
  fault_t err_code;

  assign priv_bad = rank_of(cur_level) < info.need;
  assign va_bad   = info.mapped && !info.compat && ({2'b00, va[61:0]} > VA_LIM);
  assign pa_bad   = !info.mapped && (info.direct_pa > PA_LIM);
  assign err_code = is_store ? FLT_STORE : FLT_LOAD;

  always_comb begin
    fault  = FLT_NONE;
    mapped = 1'b0;
    pa     = '0;
    if (priv_bad) begin
      fault = err_code;
    end else if (va_bad || pa_bad) begin
      fault = err_code;
    end else if (info.mapped) begin
      mapped = 1'b1;
    end else begin
      pa = info.direct_pa;
    end
  end
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
  import vseg_pkg::*;
#(
  parameter logic [63:0] MAX_VA = 64'h0000_00FF_FFFF_FFFF,
  parameter logic [63:0] MAX_PA = 64'h0000_000F_FFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [63:0] vaddr,
  input  logic [1:0]  cur_level,
  input  logic        is_store,
  output logic        rsp_valid,
  output logic        rsp_mapped,
  output logic [63:0] rsp_paddr,
  output logic [1:0]  rsp_fault
);
  seg_info_t       seg;
  fault_t          nx_fault;
  logic            nx_mapped;
  logic [VA_W-1:0] nx_pa;

  vseg_region_decode u_dec (
    .va   (vaddr),
    .info (seg)
  );

  vseg_limit_check #(
    .MAX_VA (MAX_VA),
    .MAX_PA (MAX_PA)
  ) u_chk (
    .va        (vaddr),
    .info      (seg),
    .cur_level (cur_level),
    .is_store  (is_store),
    .fault     (nx_fault),
    .mapped    (nx_mapped),
    .pa        (nx_pa)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid  <= 1'b0;
      rsp_mapped <= 1'b0;
      rsp_paddr  <= '0;
      rsp_fault  <= FLT_NONE;
    end else begin
      rsp_valid  <= 1'b1;
      rsp_mapped <= nx_mapped;
      rsp_paddr  <= nx_pa;
      rsp_fault  <= nx_fault;
    end
  end
endmodule

// File: rtl/vseg_decoder_sva.sv
module vseg_decoder_sva #(
  parameter logic [63:0] MAX_VA = 64'h0000_00FF_FFFF_FFFF,
  parameter logic [63:0] MAX_PA = 64'h0000_000F_FFFF_FFFF
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [63:0] vaddr,
  input logic [1:0]  cur_level,
  input logic        is_store,
  input logic        rsp_valid,
  input logic        rsp_mapped,
  input logic [63:0] rsp_paddr,
  input logic [1:0]  rsp_fault
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_idle_clears_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && rsp_fault == 2'd0 && !rsp_mapped));
  assert_user_high_region_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_level == 2'd0 && vaddr[63]) |=> (rsp_fault != 2'd0));
  assert_store_variant_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && is_store) |=> (rsp_fault != 2'd1));
  assert_load_variant_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !is_store) |=> (rsp_fault != 2'd2));
  assert_fault_excl_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault != 2'd0) |-> (!rsp_mapped && rsp_paddr == 64'd0));
  assert_mapped_zero_pa_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_mapped |-> (rsp_paddr == 64'd0));
  assert_pa_limit_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'd0 && !rsp_mapped) |-> (rsp_paddr <= MAX_PA));
  assert_reset_clear_R12: assert property (@(posedge clk)
    rst |=> (!rsp_valid && rsp_fault == 2'd0));
endmodule

bind vseg_decoder vseg_decoder_sva #(.MAX_VA(MAX_VA), .MAX_PA(MAX_PA)) u_sva (.*);

// File: tb/vseg_decoder_test.sv
module vseg_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] T_MAX_VA = 64'h0000_00FF_FFFF_FFFF;
  localparam logic [63:0] T_MAX_PA = 64'h0000_000F_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] vaddr = '0;
  logic [1:0]  cur_level = 2'd0;
  logic        is_store = 1'b0;
  logic        rsp_valid, rsp_mapped;
  logic [63:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vseg_decoder #(.MAX_VA(T_MAX_VA), .MAX_PA(T_MAX_PA)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr),
    .cur_level(cur_level), .is_store(is_store), .rsp_valid(rsp_valid),
    .rsp_mapped(rsp_mapped), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault));

  // expected response for the request driven at the previous falling edge
  logic        e_valid, e_mapped;
  logic [63:0] e_pa;
  logic [1:0]  e_fault;
  string       e_tag;
  bit          have_exp = 0;

  task automatic model(input logic v, input logic [63:0] va, input logic [1:0] lvl,
                       input logic st);
    int need;
    int rank;
    bit mapped;
    bit compat;
    logic [63:0] pa;
    string tag;
    compat = (va[61:31] == {31{1'b1}});
    mapped = 1; pa = 0; need = 2;
    case (va[63:62])
      2'b00: begin need = 0; tag = "R2"; end
      2'b01: begin need = 1; tag = "R2"; end
      2'b10: begin mapped = 0; pa = {5'd0, va[58:0]}; tag = "R3"; end
      default: begin
        if (!compat) tag = "R6";
        else if (va[30:29] == 2'b11) tag = "R4";
        else if (va[30:29] == 2'b10) begin need = 1; tag = "R4"; end
        else begin mapped = 0; pa = {35'd0, va[28:0]}; tag = "R5"; end
      end
    endcase
    rank = (lvl == 2'd3) ? 2 : int'(lvl);
    e_valid = v; e_mapped = 0; e_pa = 0; e_fault = 0;
    if (!v) tag = "R1";
    else if (rank < need) begin e_fault = st ? 2'd2 : 2'd1; tag = {tag, "/R7/R8"}; end
    else if (mapped && !compat && {2'b00, va[61:0]} > T_MAX_VA) begin
      e_fault = st ? 2'd2 : 2'd1; tag = {tag, "/R9/R8"};
    end else if (!mapped && pa > T_MAX_PA) begin
      e_fault = st ? 2'd2 : 2'd1; tag = {tag, "/R10/R8"};
    end else if (mapped) begin e_mapped = 1; tag = {tag, "/R11"}; end
    else e_pa = pa;
    e_tag = tag;
  endtask

  task automatic compare();
    compared++;
    if (rsp_valid !== e_valid || rsp_mapped !== e_mapped || rsp_paddr !== e_pa ||
        rsp_fault !== e_fault) begin
      mismatched++;
      $display("FAIL %s: got v=%0b m=%0b pa=%h f=%0d, expected v=%0b m=%0b pa=%h f=%0d",
               e_tag, rsp_valid, rsp_mapped, rsp_paddr, rsp_fault,
               e_valid, e_mapped, e_pa, e_fault);
    end
  endtask

  // at a falling edge: check the previous request, then drive the next one
  task automatic step(input logic v, input logic [63:0] va, input logic [1:0] lvl,
                      input logic st);
    @(negedge clk);
    if (have_exp) compare();
    req_valid = v; vaddr = va; cur_level = lvl; is_store = st;
    model(v, va, lvl, st);
    have_exp = 1;
  endtask

  task automatic all_levels(input logic [63:0] va);
    for (int l = 0; l < 4; l++) begin
      step(1'b1, va, l[1:0], 1'b0);
      step(1'b1, va, l[1:0], 1'b1);
    end
  endtask

  function automatic logic [63:0] compat_va(input logic [1:0] sub, input logic [28:0] low);
    return {2'b11, {31{1'b1}}, sub, low};
  endfunction

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    compared++;
    if (rsp_valid !== 0 || rsp_mapped !== 0 || rsp_paddr !== 0 || rsp_fault !== 0) begin
      mismatched++;
      $display("FAIL R12: got v=%0b m=%0b pa=%h f=%0d, expected all zero",
               rsp_valid, rsp_mapped, rsp_paddr, rsp_fault);
    end
    rst = 0;

    // R2 user and supervisor mapped regions, inside and over the virtual limit (R9)
    all_levels(64'h0000_0000_0040_1000);
    all_levels(64'h4000_00FF_FFFF_FFFF);
    all_levels(64'h4000_0100_0000_0000);
    all_levels(64'h0000_0100_0000_0000);
    // R9: compatibility pattern in a low region skips the virtual limit
    all_levels({2'b00, {31{1'b1}}, 31'h0000_1234});
    // R3: unmapped kernel window, cache bits flipped, PA limit (R10)
    all_levels(64'h8000_000F_FFFF_FFFF);
    all_levels(64'hB800_000F_FFFF_FFFF);
    all_levels(64'h8000_0010_0000_0000);
    // R4 / R5 compatibility sub-windows
    all_levels(compat_va(2'b11, 29'h1ABC_DEF0));
    all_levels(compat_va(2'b10, 29'h0000_0040));
    all_levels(compat_va(2'b01, 29'h1FFF_FFFF));
    all_levels(compat_va(2'b00, 29'h0123_4567));
    // R6: top region outside compatibility, inside and beyond the limit
    all_levels(64'hC000_0000_1000_0000);
    all_levels(64'hC000_0100_0000_0000);
    all_levels(64'hFFFF_FFFF_7FFF_F000);
    // R1: idle cycles between requests
    step(1'b0, 64'h8000_0000_0000_1000, 2'd2, 1'b0);
    step(1'b1, 64'h8000_0000_0000_1000, 2'd2, 1'b0);
    step(1'b0, 64'h0, 2'd0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] va;
      int kind;
      va = {$urandom, $urandom};
      kind = $urandom_range(0, 5);
      case (kind)
        0: va[61:31] = '1;
        1: va[61:40] = '0;
        2: va[58:36] = '0;
        3: begin va[63:62] = 2'b11; va[61:31] = '1; end
        default: ;
      endcase
      step($urandom_range(0, 7) != 0, va, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    step(1'b0, 64'h0, 2'd0, 1'b0);
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule